// File: doc/BRIEF.md
# Three-Stage Pipeline Stall Handshake

This block is the control glue between the fetch, decode and execute stages of a small in-order processor. It does not decode instructions and holds no register file. It decides, cycle by cycle, whether fetch may capture a new instruction word and whether decode may hand its instruction to execute. It also keeps the one-slot instruction register between fetch and decode.

Stalls travel backwards through per-stage flags rather than one global stall. Execute keeps two "done" flags, one seen by decode and one seen by fetch. Decode keeps a "decode done" flag seen by fetch. A redirect request from the execute side discards the word waiting for decode. It then parks fetch until execute reports that it has finished.

The fetch side reads a word-wide memory port whose byte lanes hold consecutive addresses starting at the fetch PC. It packs them into a big-endian instruction word. The execute datapath signals the last cycle of each multi-cycle instruction with a one-cycle completion pulse.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `dec_valid`, `ex_valid` and `instr_word` are 0 and `fetch_pc` equals RESET_PC. Both execute-done flags and the decode-done flag are 1 and the fetch-wait flag is 0, so with no redirect `fetch_en` is 1 and `decode_en` is 0 in the first cycle.
- R2: On a cycle with `fetch_en` high, lane k of `mem_rd_data` (bits 8k+7:8k, the byte at `fetch_pc`+k) is stored into `instr_word`, visible the next cycle. Lane 0 goes to bits 31:24 and lane 3 goes to bits 7:0.
- R3: `fetch_pc` increases by 4 in the cycle after `fetch_en` is high and is unchanged after any other cycle.
- R4: `decode_en` is high exactly when `dec_valid` is high, the execute-done flag toward decode is 1 and `redirect_req` is low. `ex_valid` is high in the cycle after each `decode_en` and low otherwise.
- R5: A handoff clears both execute-done flags at the same edge. `decode_en` therefore stays low from the cycle after a handoff until the cycle after `ex_last` is seen high, and may rise in that cycle.
- R6: A decode cycle spent stalled clears the decode-done flag; any other decode cycle sets it. `fetch_en` requires that flag set, and requires the slot to be empty or consumed in the same cycle. After a decode stall ends, fetch resumes one cycle after decode.
- R7: In a cycle with `redirect_req` high, `fetch_en` and `decode_en` are low and the fetch-wait flag is set. `dec_valid` is low in the next cycle, so the waiting word is dropped.
- R8: While the fetch-wait flag is set, `fetch_en` stays low until the execute-done flag toward fetch is 1. In that cycle the flag clears and fetch may go ahead at the unchanged PC. A redirect while execute is idle lets fetch run in the next cycle.
- R9: `ex_last` while execute holds no instruction has no effect on any output.
- R10: At most one instruction is in execute: `ex_valid` is never high while execute still holds an earlier instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_req | input | 1 | Wait-for-execute request from the execute side |
| ex_last | input | 1 | Execute completion pulse, high on the last cycle of the held instruction |
| mem_rd_data | input | 32 | Memory port; lane k is the byte at `fetch_pc`+k |
| fetch_en | output | 1 | Fetch captures a word this cycle |
| decode_en | output | 1 | Decode hands its instruction to execute this cycle |
| dec_valid | output | 1 | Decode input slot holds a valid word |
| ex_valid | output | 1 | One-cycle strobe: execute receives a new instruction |
| instr_word | output | 32 | Word held for decode, big-endian assembled |
| fetch_pc | output | 24 | Fetch program counter, drives the memory address |

## Verification
The assertions take two things for granted. First, `mem_rd_data` follows `fetch_pc` within the same cycle. Second, `ex_last` matters only while execute holds an instruction; pulses at other times must be ignored, not rejected. The stimulus keeps the memory bytes a pure function of the address. It drives `ex_last` and `redirect_req` at random, including pulses while execute is idle and redirects landing in every stall state. A directed redirect right after reset covers the idle-execute case of the fetch-wait rule.

// File: rtl/psc_pkg.sv
// Shared types for the pipeline stall handshake.
package psc_pkg;
    // Done flags that execute publishes toward the two earlier stages.
    typedef struct packed {
        logic to_fetch;
        logic to_decode;
    } exdone_t;

    localparam exdone_t EXDONE_IDLE = '{to_fetch: 1'b1, to_decode: 1'b1};
    localparam exdone_t EXDONE_BUSY = '{to_fetch: 1'b0, to_decode: 1'b0};
endpackage

// File: rtl/psc_exec.sv
// Execute-side occupancy tracker.
// Marks execute busy on a handoff and clears both done flags at that edge.
// Sets the flags again at the edge where the completion pulse arrives.
// Assumes: a handoff never arrives while busy (decode is gated by the flag).
module psc_exec
    import psc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hand_i,
    input  logic    last_i,
    output exdone_t done_o,
    output logic    busy_o
);
    exdone_t done_q;
    logic    busy_q;

    // Purpose: track the held instruction and the two done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= EXDONE_IDLE;
            busy_q <= 1'b0;
        end else if (busy_q && last_i) begin
            done_q <= EXDONE_IDLE;
            busy_q <= 1'b0;
        end else if (hand_i) begin
            done_q <= EXDONE_BUSY;
            busy_q <= 1'b1;
        end
    end

    assign done_o = done_q;
    assign busy_o = busy_q;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        hand_i |-> !busy_q); // R10
    AST_HAND_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        hand_i |=> (!done_q.to_fetch && !done_q.to_decode)); // R5
    AST_IDLE_LAST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !hand_i && last_i) |=> (!busy_q && done_q == EXDONE_IDLE)); // R9
endmodule

// File: rtl/psc_decode.sv
// Decode-stage gating.
// Passes the slot word forward when execute reports done and no redirect kills it.
// Publishes a decode-done flag toward fetch that drops after a stalled cycle.
// Assumes: slot_valid_i is the registered slot flag owned by fetch.
module psc_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_valid_i,
    input  logic done_d_i,
    input  logic redirect_i,
    output logic pass_o,
    output logic ex_valid_o,
    output logic dec_done_o
);
    logic ex_valid_q;
    logic dec_done_q;

    // Purpose: decide whether this cycle hands an instruction to execute.
    always_comb begin
        pass_o = done_d_i && slot_valid_i && !redirect_i;
    end

    // Purpose: register the execute strobe and the decode-done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid_q <= 1'b0;
            dec_done_q <= 1'b1;
        end else if (!done_d_i) begin
            ex_valid_q <= 1'b0;
            dec_done_q <= 1'b0;
        end else begin
            ex_valid_q <= pass_o;
            dec_done_q <= 1'b1;
        end
    end

    assign ex_valid_o = ex_valid_q;
    assign dec_done_o = dec_done_q;

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |=> ex_valid_q); // R4
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid_q |=> !ex_valid_q); // R5
endmodule

// File: rtl/psc_fetch.sv
// Fetch-stage gating, PC and decode input slot.
// Packs memory byte lanes big-endian, advances PC only on a capture, and parks
// on a redirect until execute reports done toward fetch.
// Assumes: mem_i reflects the bytes at pc_o .. pc_o+LANES-1 in the same cycle.
module psc_fetch #(
    parameter int BYTE_W   = 8,
    parameter int LANES    = 4,
    parameter int PC_W     = 24,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      redirect_i,
    input  logic                      done_f_i,
    input  logic                      dec_done_i,
    input  logic                      pass_i,
    input  logic [BYTE_W*LANES-1:0]   mem_i,
    output logic                      fetch_o,
    output logic                      slot_valid_o,
    output logic [BYTE_W*LANES-1:0]   word_o,
    output logic [PC_W-1:0]           pc_o
);
    localparam int WORD_W = BYTE_W * LANES;
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(LANES);

    logic              fw_q;
    logic              slot_q;
    logic [WORD_W-1:0] word_q;
    logic [PC_W-1:0]   pc_q;
    logic [WORD_W-1:0] packed_w;

    // Lane k (lowest address first) lands in the k-th most significant byte.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign packed_w[WORD_W-1-k*BYTE_W -: BYTE_W] = mem_i[k*BYTE_W +: BYTE_W];
    end

    // Purpose: decide whether fetch captures a word this cycle.
    always_comb begin
        fetch_o = !redirect_i && (!fw_q || done_f_i) && dec_done_i
                  && (!slot_q || pass_i);
    end

    // Purpose: fetch-wait flag, set by a redirect, cleared once execute is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fw_q <= 1'b0;
        end else if (redirect_i) begin
            fw_q <= 1'b1;
        end else if (fw_q && done_f_i) begin
            fw_q <= 1'b0;
        end
    end

    // Purpose: decode input slot occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= 1'b0;
        end else if (redirect_i) begin
            slot_q <= 1'b0;
        end else if (fetch_o) begin
            slot_q <= 1'b1;
        end else if (pass_i) begin
            slot_q <= 1'b0;
        end
    end

    // Purpose: capture the word and step the PC on a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            pc_q   <= RESET_PC;
        end else if (fetch_o) begin
            word_q <= packed_w;
            pc_q   <= pc_q + PC_STEP;
        end
    end

    assign slot_valid_o = slot_q;
    assign word_o       = word_q;
    assign pc_o         = pc_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> (pc_q == $past(pc_q) + PC_STEP)); // R3
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_o |=> $stable(pc_q)); // R3
    AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> !slot_q); // R7
    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_q && !done_f_i) |-> !fetch_o); // R8
endmodule

// File: rtl/pipe_stall_ctrl.sv
// Top of the three-stage stall handshake.
// Wires the fetch, decode and execute control pieces through their done flags.
// Assumes: ex_last is driven by the execute datapath; mem_rd_data follows fetch_pc.
module pipe_stall_ctrl #(
    parameter int BYTE_W   = 8,
    parameter int LANES    = 4,
    parameter int PC_W     = 24,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    redirect_req,
    input  logic                    ex_last,
    input  logic [BYTE_W*LANES-1:0] mem_rd_data,
    output logic                    fetch_en,
    output logic                    decode_en,
    output logic                    dec_valid,
    output logic                    ex_valid,
    output logic [BYTE_W*LANES-1:0] instr_word,
    output logic [PC_W-1:0]         fetch_pc
);
    import psc_pkg::*;

    exdone_t ex_done;
    logic    ex_busy;
    logic    dec_done;

    psc_fetch #(
        .BYTE_W  (BYTE_W),
        .LANES   (LANES),
        .PC_W    (PC_W),
        .RESET_PC(RESET_PC)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .redirect_i  (redirect_req),
        .done_f_i    (ex_done.to_fetch),
        .dec_done_i  (dec_done),
        .pass_i      (decode_en),
        .mem_i       (mem_rd_data),
        .fetch_o     (fetch_en),
        .slot_valid_o(dec_valid),
        .word_o      (instr_word),
        .pc_o        (fetch_pc)
    );

    psc_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_valid_i(dec_valid),
        .done_d_i    (ex_done.to_decode),
        .redirect_i  (redirect_req),
        .pass_o      (decode_en),
        .ex_valid_o  (ex_valid),
        .dec_done_o  (dec_done)
    );

    psc_exec u_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .hand_i(decode_en),
        .last_i(ex_last),
        .done_o(ex_done),
        .busy_o(ex_busy)
    );

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !decode_en && !redirect_req) |-> !fetch_en); // R6
    AST_EXV_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> (ex_busy && !ex_done.to_decode)); // R10
endmodule

// File: tb/pipe_stall_ctrl_tb.sv
module pipe_stall_ctrl_tb;
    localparam int PC_W = 24;
    localparam int MAX_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_req = 1'b0;
    logic        ex_last = 1'b0;
    logic [31:0] mem_rd_data;
    logic        fetch_en, decode_en, dec_valid, ex_valid;
    logic [31:0] instr_word;
    logic [PC_W-1:0] fetch_pc;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference state
    logic [PC_W-1:0] m_pc;
    logic [31:0]     m_word;
    logic m_dv, m_exv, m_busy, m_df, m_dd, m_decdone, m_fw;

    always #2 clk = ~clk;

    pipe_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .redirect_req(redirect_req), .ex_last(ex_last),
        .mem_rd_data(mem_rd_data), .fetch_en(fetch_en), .decode_en(decode_en),
        .dec_valid(dec_valid), .ex_valid(ex_valid), .instr_word(instr_word),
        .fetch_pc(fetch_pc)
    );

    function automatic logic [7:0] byte_at(input logic [PC_W-1:0] a);
        return (a[7:0] * 8'd13) ^ (a[15:8] + 8'h5A);
    endfunction

    function automatic logic [31:0] word_at(input logic [PC_W-1:0] a);
        return {byte_at(a), byte_at(a + 1), byte_at(a + 2), byte_at(a + 3)};
    endfunction

    // memory model: lane k = byte at fetch_pc + k
    always_comb begin
        for (int k = 0; k < 4; k++) mem_rd_data[8*k +: 8] = byte_at(fetch_pc + PC_W'(k));
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_word = '0; m_dv = 0; m_exv = 0; m_busy = 0;
        m_df = 1; m_dd = 1; m_decdone = 1; m_fw = 0;
    endtask

    // compare outputs against the reference, then advance the reference one edge
    task automatic compare_and_step();
        logic dec_e, fet_e;
        string tf, td;
        dec_e = m_dd && m_dv && !redirect_req;
        fet_e = !redirect_req && (!m_fw || m_df) && m_decdone && (!m_dv || dec_e);
        tf = redirect_req ? "R7" : (m_fw ? "R8" : ((ex_last && !m_busy) ? "R9" : "R6"));
        td = redirect_req ? "R7" : ((ex_last && !m_busy) ? "R9" : "R5");
        chk(fetch_en == fet_e, tf, "fetch_en", 32'(fetch_en), 32'(fet_e));
        chk(decode_en == dec_e, td, "decode_en", 32'(decode_en), 32'(dec_e));
        chk(dec_valid == m_dv, "R7", "dec_valid", 32'(dec_valid), 32'(m_dv));
        chk(ex_valid == m_exv, m_busy ? "R10" : "R4", "ex_valid", 32'(ex_valid), 32'(m_exv));
        chk(fetch_pc == m_pc, "R3", "fetch_pc", 32'(fetch_pc), 32'(m_pc));
        chk(instr_word == m_word, "R2", "instr_word", instr_word, m_word);
        // next state
        m_exv = dec_e;
        m_decdone = m_dd;
        if (m_busy && ex_last) begin m_df = 1; m_dd = 1; m_busy = 0; end
        else if (dec_e) begin m_df = 0; m_dd = 0; m_busy = 1; end
        if (redirect_req) m_fw = 1;
        else if (m_fw && m_df) m_fw = 0;
        if (redirect_req) m_dv = 0;
        else if (fet_e) m_dv = 1;
        else if (dec_e) m_dv = 0;
        if (fet_e) begin m_word = word_at(m_pc); m_pc = m_pc + 4; end
    endtask

    task automatic one_cycle(input bit r, input bit l);
        @(negedge clk);
        redirect_req = r;
        ex_last = l;
        #1;
        compare_and_step();
    endtask

    task automatic run_phase(input int n, input int p_redir, input int p_last);
        for (int i = 0; i < n; i++) begin
            one_cycle(($urandom % 100) < p_redir, ($urandom % 100) < p_last);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // watchdog
    initial begin
        wait (cyc >= MAX_CYC);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240306);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(dec_valid == 1'b0, "R1", "dec_valid", 32'(dec_valid), 0);
        chk(ex_valid == 1'b0, "R1", "ex_valid", 32'(ex_valid), 0);
        chk(instr_word == 32'h0, "R1", "instr_word", instr_word, 0);
        chk(fetch_pc == '0, "R1", "fetch_pc", 32'(fetch_pc), 0);
        chk(fetch_en == 1'b1, "R1", "fetch_en", 32'(fetch_en), 1);
        chk(decode_en == 1'b0, "R1", "decode_en", 32'(decode_en), 0);
        // R8 directed: redirect while execute idle, fetch next cycle at PC 0
        compare_and_step_with(1'b1, 1'b0);
        one_cycle(1'b0, 1'b0);
        // R9 directed: completion pulses with execute idle are ignored
        one_cycle(1'b0, 1'b1);
        // single-cycle execute stream, then slower execute
        run_phase(1500, 0, 100);
        run_phase(1500, 0, 25);
        // R7 / R8 mixes
        run_phase(3000, 10, 50);
        run_phase(2000, 30, 15);
        // directed: redirect on consecutive cycles, then long busy
        one_cycle(1'b1, 1'b0);
        one_cycle(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) one_cycle(1'b0, 1'b0);
        one_cycle(1'b0, 1'b1);
        run_phase(1000, 5, 60);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // first cycle after reset already sampled; drive inputs for it now
    task automatic compare_and_step_with(input bit r, input bit l);
        redirect_req = r;
        ex_last = l;
        #1;
        compare_and_step();
    endtask
endmodule